// File: doc/BRIEF.md
# Four-channel serial audio port (slave, two data lines per direction)

This block connects a chip to an external audio master over I2S in slave mode. It carries four channels, a front stereo pair and a rear stereo pair, on two serial data lines. In each direction the two lines share one bit clock and one word-select line. The receive side turns both input lines into four 20-bit two's-complement samples. It raises a one-cycle strobe once per complete frame. The transmit side takes four 20-bit samples and shifts them out on two output lines.

The receive and transmit directions each get their own bit clock and word select from outside. The two directions need not be related to each other. Every pin is brought into the single system clock through a two-flop synchronizer, and all edge detection happens in that clock. Each half period of either bit clock must therefore last at least four system clock cycles.

The word length is not configured. It follows from the number of bit clocks between word-select transitions, and any length from 1 to 32 bits is handled.

Top module: `i2s_quad_port`

## Requirements
- R1: Word select low selects the left word and high selects the right word. The bit sampled on the first bit-clock rising edge after a word-select change is the last bit of the previous word. The next rising edge carries the MSB of the new word. A 20-bit word is captured exactly, MSB first, two's complement.
- R2: For a received word shorter than 20 bits, the bits fill the output from bit 19 downward and the remaining low bits are zero.
- R3: For a received word longer than 20 bits, the first 20 bits sent are kept and all later bits are ignored.
- R4: Both input lines are captured in parallel from the shared bit clock and word select. Line front feeds `rx_front_l`/`rx_front_r` and line rear feeds `rx_rear_l`/`rx_rear_r`.
- R5: `rx_valid` is high for exactly one system clock cycle per frame. It rises three system clock cycles after the bit-clock rising edge whose word select is low and that ends a right word, and is not high two cycles after that edge. The four sample outputs change together in that cycle and hold their values at all other times.
- R6: A frame whose left word began before the first word-select change seen after reset produces no strobe and no output update.
- R7: Each transmit bit changes three system clock cycles after a falling bit-clock edge and is stable two cycles after that edge. The left MSB goes out in the bit slot after word select falls, and the right MSB in the slot after it rises.
- R8: The transmitter sends the first W bits of the 20-bit sample for a W-bit word when W is 20 or less. For longer words it sends all 20 bits and then zeros in the remaining slots.
- R9: All four transmit samples are taken at the start of the left word. Changes to the sample inputs later in the same frame do not affect that frame's left or right words.
- R10: Receive and transmit run from unrelated bit clocks at the same time without affecting each other.
- R11: After reset the sample outputs are zero, `rx_valid` is low and both transmit lines are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_sck | input | 1 | Receive bit clock from the external master |
| rx_ws | input | 1 | Receive word select (0 left, 1 right) |
| rx_sd_front | input | 1 | Receive serial data, front pair |
| rx_sd_rear | input | 1 | Receive serial data, rear pair |
| rx_front_l | output | 20 | Captured front left sample |
| rx_front_r | output | 20 | Captured front right sample |
| rx_rear_l | output | 20 | Captured rear left sample |
| rx_rear_r | output | 20 | Captured rear right sample |
| rx_valid | output | 1 | One-cycle strobe, new frame on the sample outputs |
| tx_sck | input | 1 | Transmit bit clock from the external master |
| tx_ws | input | 1 | Transmit word select (0 left, 1 right) |
| tx_front_l | input | 20 | Front left sample to send |
| tx_front_r | input | 20 | Front right sample to send |
| tx_rear_l | input | 20 | Rear left sample to send |
| tx_rear_r | input | 20 | Rear right sample to send |
| tx_sd_front | output | 1 | Transmit serial data, front pair |
| tx_sd_rear | output | 1 | Transmit serial data, rear pair |

## Verification
Each result passes two synchronizer flops and one state register, so it is due three system cycles after the pin edge that causes it. The receive strobe and samples are due three cycles after the closing bit-clock rise, and the transmit bit three cycles after the falling edge. The bench drives every pin on a falling system edge and samples on later falling edges. It counts those edges from the one that drove the bit clock. It checks that the result is absent on the second edge and present on the third, then checks the strobe is gone on the fourth. Transmit bits are also compared with the expected frame bit just before the next rising bit clock.

// File: rtl/i2s_quad_pkg.sv
package i2s_quad_pkg;

    // Significant bits kept per audio word.
    localparam int SAMPLE_BITS = 20;
    // Serial data lines per direction.
    localparam int LINE_CNT    = 2;
    // Line index of each stereo pair.
    localparam int LINE_FRONT  = 0;
    localparam int LINE_REAR   = 1;
    // Synchronizer depth for the external pins.
    localparam int SYNC_DEPTH  = 2;

endpackage

// File: rtl/i2s_pin_sync.sv
module i2s_pin_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = i2s_quad_pkg::SYNC_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d;
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_comb begin
        chain_d[0] = pin_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/i2s_quad_rx.sv
module i2s_quad_rx #(
    parameter int SAMPLE_W = i2s_quad_pkg::SAMPLE_BITS,
    parameter int LINES    = i2s_quad_pkg::LINE_CNT
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            sck_i,
    input  logic                            ws_i,
    input  logic [LINES-1:0]                sd_i,
    output logic [LINES-1:0][SAMPLE_W-1:0]  left_o,
    output logic [LINES-1:0][SAMPLE_W-1:0]  right_o,
    output logic                            valid_o
);

    localparam int                CNT_W   = $clog2(SAMPLE_W + 1);
    localparam logic [CNT_W-1:0]  CNT_MAX = CNT_W'(SAMPLE_W);

    typedef logic [LINES-1:0][SAMPLE_W-1:0] word_vec_t;

    typedef struct packed {
        logic             sck_prev;
        logic             ws_prev;
        logic             primed;
        logic             word_ok;
        logic             got_left;
        logic             valid;
        logic [CNT_W-1:0] cnt;
        word_vec_t        acc;
        word_vec_t        stage;
        word_vec_t        out_l;
        word_vec_t        out_r;
    } rx_state_t;

    rx_state_t q;
    rx_state_t d;
    logic      rise;
    logic      ws_edge;
    word_vec_t acc_next;

    always_comb begin
        d          = q;
        d.valid    = 1'b0;
        d.sck_prev = sck_i;
        rise       = sck_i && !q.sck_prev;
        ws_edge    = rise && q.primed && (ws_i != q.ws_prev);

        // Place the incoming bit at the next free position, MSB first.
        acc_next = q.acc;
        for (int l = 0; l < LINES; l++) begin
            for (int b = 0; b < SAMPLE_W; b++) begin
                if ((q.cnt < CNT_MAX) && (int'(q.cnt) == SAMPLE_W - 1 - b)) begin
                    acc_next[l][b] = sd_i[l];
                end
            end
        end

        if (rise) begin
            d.primed  = 1'b1;
            d.ws_prev = ws_i;
            if (ws_edge) begin
                // This bit closes the word of channel ws_prev.
                if (q.word_ok) begin
                    if (!q.ws_prev) begin
                        d.stage    = acc_next;
                        d.got_left = 1'b1;
                    end else begin
                        if (q.got_left) begin
                            d.out_l = q.stage;
                            d.out_r = acc_next;
                            d.valid = 1'b1;
                        end
                        d.got_left = 1'b0;
                    end
                end
                d.acc     = '0;
                d.cnt     = '0;
                d.word_ok = 1'b1;
            end else begin
                d.acc = acc_next;
                if (q.cnt < CNT_MAX) begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign left_o  = q.out_l;
    assign right_o = q.out_r;
    assign valid_o = q.valid;

    // R5
    rx_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |=> !q.valid);

    // R5
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q.valid |-> ($stable(q.out_l) && $stable(q.out_r)));

    // R3
    rx_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_MAX);

    // R6
    rx_frame_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |-> $past(q.got_left));

endmodule

// File: rtl/i2s_quad_tx.sv
module i2s_quad_tx #(
    parameter int SAMPLE_W = i2s_quad_pkg::SAMPLE_BITS,
    parameter int LINES    = i2s_quad_pkg::LINE_CNT
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            sck_i,
    input  logic                            ws_i,
    input  logic [LINES-1:0][SAMPLE_W-1:0]  left_i,
    input  logic [LINES-1:0][SAMPLE_W-1:0]  right_i,
    output logic [LINES-1:0]                sd_o
);

    typedef logic [LINES-1:0][SAMPLE_W-1:0] word_vec_t;

    typedef struct packed {
        logic             sck_prev;
        logic             ws_last;
        logic             pend;
        logic             pend_ch;
        logic [LINES-1:0] sd;
        word_vec_t        sh;
        word_vec_t        hold;
    } tx_state_t;

    tx_state_t q;
    tx_state_t d;
    logic      fall;

    always_comb begin
        d          = q;
        d.sck_prev = sck_i;
        fall       = !sck_i && q.sck_prev;

        if (fall) begin
            d.ws_last = ws_i;
            // Default: next bit of the running word, zeros once it is used up.
            for (int l = 0; l < LINES; l++) begin
                d.sd[l] = q.sh[l][SAMPLE_W-1];
                d.sh[l] = q.sh[l] << 1;
            end
            // A word starts one slot after its word-select change.
            if (q.pend) begin
                if (!q.pend_ch) begin
                    for (int l = 0; l < LINES; l++) begin
                        d.sd[l] = left_i[l][SAMPLE_W-1];
                        d.sh[l] = left_i[l] << 1;
                    end
                    d.hold = right_i;
                end else begin
                    for (int l = 0; l < LINES; l++) begin
                        d.sd[l] = q.hold[l][SAMPLE_W-1];
                        d.sh[l] = q.hold[l] << 1;
                    end
                end
                d.pend = 1'b0;
            end
            if (ws_i != q.ws_last) begin
                d.pend    = 1'b1;
                d.pend_ch = ws_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sd_o = q.sd;

    // R7
    tx_sd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(q.sd));

    // R9
    tx_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fall && q.pend && !q.pend_ch) |=> $stable(q.hold));

endmodule

// File: rtl/i2s_quad_port.sv
module i2s_quad_port
    import i2s_quad_pkg::*;
#(
    parameter int SAMPLE_W = SAMPLE_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_sck,
    input  logic                rx_ws,
    input  logic                rx_sd_front,
    input  logic                rx_sd_rear,
    output logic [SAMPLE_W-1:0] rx_front_l,
    output logic [SAMPLE_W-1:0] rx_front_r,
    output logic [SAMPLE_W-1:0] rx_rear_l,
    output logic [SAMPLE_W-1:0] rx_rear_r,
    output logic                rx_valid,
    input  logic                tx_sck,
    input  logic                tx_ws,
    input  logic [SAMPLE_W-1:0] tx_front_l,
    input  logic [SAMPLE_W-1:0] tx_front_r,
    input  logic [SAMPLE_W-1:0] tx_rear_l,
    input  logic [SAMPLE_W-1:0] tx_rear_r,
    output logic                tx_sd_front,
    output logic                tx_sd_rear
);

    localparam int RX_PINS = 2 + LINE_CNT;

    logic [RX_PINS-1:0]                   rx_pins;
    logic [RX_PINS-1:0]                   rx_sync;
    logic [1:0]                           tx_pins;
    logic [1:0]                           tx_sync;
    logic [LINE_CNT-1:0]                  rx_sd_s;
    logic [LINE_CNT-1:0][SAMPLE_W-1:0]    rx_left;
    logic [LINE_CNT-1:0][SAMPLE_W-1:0]    rx_right;
    logic [LINE_CNT-1:0][SAMPLE_W-1:0]    tx_left;
    logic [LINE_CNT-1:0][SAMPLE_W-1:0]    tx_right;
    logic [LINE_CNT-1:0]                  tx_sd;

    assign rx_pins = {rx_sd_rear, rx_sd_front, rx_ws, rx_sck};
    assign tx_pins = {tx_ws, tx_sck};
    assign rx_sd_s = rx_sync[RX_PINS-1:2];

    i2s_pin_sync #(.WIDTH(RX_PINS), .STAGES(SYNC_DEPTH)) u_rx_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (rx_pins),
        .sync_o (rx_sync)
    );

    i2s_pin_sync #(.WIDTH(2), .STAGES(SYNC_DEPTH)) u_tx_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (tx_pins),
        .sync_o (tx_sync)
    );

    i2s_quad_rx #(.SAMPLE_W(SAMPLE_W), .LINES(LINE_CNT)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_i   (rx_sync[0]),
        .ws_i    (rx_sync[1]),
        .sd_i    (rx_sd_s),
        .left_o  (rx_left),
        .right_o (rx_right),
        .valid_o (rx_valid)
    );

    assign tx_left[LINE_FRONT]  = tx_front_l;
    assign tx_left[LINE_REAR]   = tx_rear_l;
    assign tx_right[LINE_FRONT] = tx_front_r;
    assign tx_right[LINE_REAR]  = tx_rear_r;

    i2s_quad_tx #(.SAMPLE_W(SAMPLE_W), .LINES(LINE_CNT)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_i   (tx_sync[0]),
        .ws_i    (tx_sync[1]),
        .left_i  (tx_left),
        .right_i (tx_right),
        .sd_o    (tx_sd)
    );

    assign rx_front_l  = rx_left[LINE_FRONT];
    assign rx_rear_l   = rx_left[LINE_REAR];
    assign rx_front_r  = rx_right[LINE_FRONT];
    assign rx_rear_r   = rx_right[LINE_REAR];
    assign tx_sd_front = tx_sd[LINE_FRONT];
    assign tx_sd_rear  = tx_sd[LINE_REAR];

endmodule

// File: tb/tb_i2s_quad_port.sv
module tb_i2s_quad_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_sck = 1'b1, rx_ws = 1'b0, rx_sd_front = 1'b0, rx_sd_rear = 1'b0;
    logic [19:0] rx_front_l, rx_front_r, rx_rear_l, rx_rear_r;
    logic        rx_valid;
    logic        tx_sck = 1'b1, tx_ws = 1'b1;
    logic [19:0] tx_front_l = '0, tx_front_r = '0, tx_rear_l = '0, tx_rear_r = '0;
    logic        tx_sd_front, tx_sd_rear;

    int checks = 0;
    int fails  = 0;
    int nvalid = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    i2s_quad_port dut (
        .clk(clk), .rst_n(rst_n),
        .rx_sck(rx_sck), .rx_ws(rx_ws), .rx_sd_front(rx_sd_front), .rx_sd_rear(rx_sd_rear),
        .rx_front_l(rx_front_l), .rx_front_r(rx_front_r),
        .rx_rear_l(rx_rear_l), .rx_rear_r(rx_rear_r), .rx_valid(rx_valid),
        .tx_sck(tx_sck), .tx_ws(tx_ws),
        .tx_front_l(tx_front_l), .tx_front_r(tx_front_r),
        .tx_rear_l(tx_rear_l), .tx_rear_r(tx_rear_r),
        .tx_sd_front(tx_sd_front), .tx_sd_rear(tx_sd_rear)
    );

    always @(negedge clk) if (rst_n && rx_valid) nvalid++;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [19:0] rx_exp(input logic [31:0] v, input int w);
        logic [31:0] t;
        if (w >= 20) t = v >> (w - 20);
        else         t = v << (20 - w);
        return t[19:0];
    endfunction

    function automatic logic [31:0] rand_word(input int w);
        logic [31:0] m;
        m = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
        return $urandom & m;
    endfunction

    function automatic logic tx_bit(input logic [19:0] s, input int p);
        if (p >= 1 && p <= 20) return s[20 - p];
        return 1'b0;
    endfunction

    function automatic string len_req(input int w);
        if (w == 20) return "R1";
        if (w < 20)  return "R2";
        return "R3";
    endfunction

    // ---------------- receive side ----------------
    bit          rx_pend = 1'b0;
    logic [19:0] rx_e [4];
    string       rx_req = "R1";
    logic [31:0] prx_fr = '0, prx_rr = '0;
    int          prx_w = 0;
    int          rx_frames = 0;

    task automatic rx_slot(input logic ws, input logic bf, input logic br, input bit close_chk);
        rx_sck = 1'b0; rx_ws = ws; rx_sd_front = bf; rx_sd_rear = br;
        repeat (4) @(negedge clk);
        rx_sck = 1'b1;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            if (close_chk && rx_pend) begin
                if (k == 2) check(rx_valid == 1'b0, "R5", "strobe before third cycle", 32'(rx_valid), 0);
                if (k == 3) begin
                    check(rx_valid == 1'b1, "R5", "strobe on third cycle", 32'(rx_valid), 1);
                    check(rx_front_l == rx_e[0], rx_req, "front left", 32'(rx_front_l), 32'(rx_e[0]));
                    check(rx_front_r == rx_e[1], rx_req, "front right", 32'(rx_front_r), 32'(rx_e[1]));
                    check(rx_rear_l == rx_e[2], "R4", "rear left", 32'(rx_rear_l), 32'(rx_e[2]));
                    check(rx_rear_r == rx_e[3], "R4", "rear right", 32'(rx_rear_r), 32'(rx_e[3]));
                end
                if (k == 4) check(rx_valid == 1'b0, "R5", "strobe width", 32'(rx_valid), 0);
            end
        end
        if (close_chk) rx_pend = 1'b0;
    endtask

    task automatic rx_frame(input int w, input logic [31:0] fl, input logic [31:0] fr,
                            input logic [31:0] rl, input logic [31:0] rr);
        for (int i = 0; i < 2 * w; i++) begin
            if (i == 0)
                rx_slot(1'b0, (prx_w > 0) ? prx_fr[0] : 1'b0, (prx_w > 0) ? prx_rr[0] : 1'b0, 1'b1);
            else if (i <= w)
                rx_slot((i < w) ? 1'b0 : 1'b1, fl[w - i], rl[w - i], 1'b0);
            else
                rx_slot(1'b1, fr[2 * w - i], rr[2 * w - i], 1'b0);
        end
        rx_e[0] = rx_exp(fl, w); rx_e[1] = rx_exp(fr, w);
        rx_e[2] = rx_exp(rl, w); rx_e[3] = rx_exp(rr, w);
        rx_req  = len_req(w);
        rx_pend = 1'b1;
        prx_fr = fr; prx_rr = rr; prx_w = w;
        rx_frames++;
    endtask

    task automatic rx_run();
        // R6: partial left word right after reset, then a full right word only.
        for (int i = 0; i < 3; i++) rx_slot(1'b0, 1'($urandom), 1'($urandom), 1'b0);
        for (int i = 0; i < 16; i++) rx_slot(1'b1, 1'($urandom), 1'($urandom), 1'b0);
        // R1: extreme two's-complement values at exactly 20 bits.
        rx_frame(20, 32'h80000, 32'h7FFFF, 32'hFFFFF, 32'h00001);
        check(nvalid == 0, "R6", "no strobe for incomplete first frame", 32'(nvalid), 0);
        rx_frame(16, rand_word(16), rand_word(16), rand_word(16), rand_word(16));
        rx_frame(24, rand_word(24), rand_word(24), rand_word(24), rand_word(24));
        rx_frame(32, 32'hFFFF_FFFF, 32'h8000_0001, rand_word(32), rand_word(32));
        rx_frame(1, 32'h1, 32'h0, 32'h0, 32'h1);
        rx_frame(8, rand_word(8), rand_word(8), rand_word(8), rand_word(8));
        for (int n = 0; n < 6; n++) begin
            int w;
            w = 1 + int'($urandom % 32);
            rx_frame(w, rand_word(w), rand_word(w), rand_word(w), rand_word(w));
        end
        rx_slot(1'b0, prx_fr[0], prx_rr[0], 1'b1);
        repeat (20) @(negedge clk);
        // R5: outputs hold the last frame with no further strobe
        check(rx_front_l == rx_e[0] && rx_rear_r == rx_e[3], "R5", "outputs hold",
              32'(rx_front_l), 32'(rx_e[0]));
        check(nvalid == rx_frames, "R6", "one strobe per complete frame", 32'(nvalid), 32'(rx_frames));
    endtask

    // ---------------- transmit side ----------------
    bit          ptx_ok = 1'b0;
    logic [19:0] ptx_fr = '0, ptx_rr = '0;
    int          ptx_w = 0;
    bit          last_ok = 1'b0;
    logic        last_f = 1'b0, last_r = 1'b0;

    task automatic tx_slot(input logic ws, input bit chk, input logic ef, input logic er, input string req);
        tx_sck = 1'b0; tx_ws = ws;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            if (k == 2 && chk && last_ok)
                check({tx_sd_front, tx_sd_rear} == {last_f, last_r}, "R7", "bit changed before third cycle",
                      32'({tx_sd_front, tx_sd_rear}), 32'({last_f, last_r}));
            if (k == 5 && chk)
                check({tx_sd_front, tx_sd_rear} == {ef, er}, req, "transmit bit",
                      32'({tx_sd_front, tx_sd_rear}), 32'({ef, er}));
        end
        tx_sck = 1'b1;
        repeat (5) @(negedge clk);
        last_ok = chk; last_f = ef; last_r = er;
    endtask

    task automatic tx_frame(input int w, input logic [19:0] fl, input logic [19:0] fr,
                            input logic [19:0] rl, input logic [19:0] rr, input bit mid, input string req);
        tx_front_l = fl; tx_front_r = fr; tx_rear_l = rl; tx_rear_r = rr;
        for (int i = 0; i < 2 * w; i++) begin
            if (mid && i == 2) begin
                tx_front_l = 20'($urandom); tx_front_r = 20'($urandom);
                tx_rear_l  = 20'($urandom); tx_rear_r  = 20'($urandom);
            end
            if (i == 0)
                tx_slot(1'b0, ptx_ok, tx_bit(ptx_fr, ptx_w), tx_bit(ptx_rr, ptx_w), req);
            else if (i <= w)
                tx_slot((i < w) ? 1'b0 : 1'b1, 1'b1, tx_bit(fl, i), tx_bit(rl, i), req);
            else
                tx_slot(1'b1, 1'b1, tx_bit(fr, i - w), tx_bit(rr, i - w), req);
        end
        ptx_ok = 1'b1; ptx_fr = fr; ptx_rr = rr; ptx_w = w;
    endtask

    task automatic tx_run();
        for (int i = 0; i < 3; i++) tx_slot(1'b1, 1'b0, 1'b0, 1'b0, "R7");
        tx_frame(20, 20'h80000, 20'h7FFFF, 20'hA5A5A, 20'h00001, 1'b0, "R7");
        tx_frame(24, 20'($urandom), 20'($urandom), 20'hFFFFF, 20'hFFFFF, 1'b0, "R8");
        tx_frame(32, 20'($urandom), 20'($urandom), 20'($urandom), 20'($urandom), 1'b0, "R8");
        tx_frame(16, 20'($urandom), 20'($urandom), 20'($urandom), 20'($urandom), 1'b0, "R8");
        tx_frame(1, 20'hFFFFF, 20'h00000, 20'h80000, 20'h7FFFF, 1'b0, "R8");
        tx_frame(20, 20'($urandom), 20'($urandom), 20'($urandom), 20'($urandom), 1'b1, "R9");
        tx_frame(12, 20'($urandom), 20'($urandom), 20'($urandom), 20'($urandom), 1'b1, "R9");
        for (int n = 0; n < 5; n++) begin
            int w;
            w = 1 + int'($urandom % 32);
            tx_frame(w, 20'($urandom), 20'($urandom), 20'($urandom), 20'($urandom), 1'b0, "R8");
        end
        tx_slot(1'b0, 1'b1, tx_bit(ptx_fr, ptx_w), tx_bit(ptx_rr, ptx_w), "R8");
    endtask

    initial begin
        void'($urandom(32'd7741));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11
        check(rx_valid == 1'b0, "R11", "strobe after reset", 32'(rx_valid), 0);
        check(rx_front_l == 0 && rx_front_r == 0 && rx_rear_l == 0 && rx_rear_r == 0, "R11",
              "samples after reset", 32'(rx_front_l | rx_front_r | rx_rear_l | rx_rear_r), 0);
        check({tx_sd_front, tx_sd_rear} == 2'b00, "R11", "transmit lines after reset",
              32'({tx_sd_front, tx_sd_rear}), 0);
        // R10: both directions on unrelated bit clocks at once
        fork
            rx_run();
            tx_run();
        join
        check(nvalid == rx_frames, "R10", "receive unaffected by concurrent transmit",
              32'(nvalid), 32'(rx_frames));
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule